// File: doc/BRIEF.md
# Paged Line Scan Address Generator

This block produces the common (row) scan sequence for a 65-row matrix panel whose display memory is organised as eight pages of eight rows, plus one extra indicator row held in a ninth page. On each line-clock enable it advances one scan step. A frame has 65 steps. The first 64 steps walk the main display rows. The last step scans the indicator row.

For every main step the block adds a programmable start line to the step number, modulo 64. Changing the start line therefore scrolls the picture vertically. The resulting memory row is presented both as a page and row-within-page address and as a flat row address. The same step also selects a physical common output, in ascending or descending order depending on a direction control. The indicator row ignores the start line and always drives its own dedicated common output.

The start line and direction inputs are captured only at the frame boundary, so a frame is never torn. A frame strobe marks the first step of each frame.

Top module: `line_scan_gen`

## Requirements
- R1: After reset the scan step is 0, the captured start line is 0 and the captured direction is ascending, so the outputs show row 0, page 0, line 0 and common 0.
- R2: The scan step advances by one only on a clock edge where `line_en` is high. While `line_en` is low, every output holds.
- R3: A frame has 65 steps, numbered 0 to 64. An enabled edge at step 64 returns the step to 0.
- R4: For step k below 64, the memory row is (start + k) mod 64. `page_addr` is that row divided by 8, `page_line` is the row mod 8, and `row_addr` equals the row.
- R5: At step 64, `indicator` is 1, `page_addr` is 8, `page_line` is 0, `row_addr` is 64 and `com_index` is 64, whatever the start line and direction are.
- R6: For step k below 64, `com_index` is k when the captured direction is ascending (`reverse` captured as 0) and 63 − k when it is descending (`reverse` captured as 1).
- R7: `com_sel` has exactly one bit set, and that bit is the one at position `com_index` (bit 64 is the indicator common).
- R8: `start_line` and `reverse` are captured only on an enabled edge at step 64. Changes to them at any other time have no effect on the frame in progress.
- R9: `frame_start` is high exactly when `line_en` is high and the scan step is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_en | input | 1 | Line clock enable; advances the scan |
| start_line | input | 6 | Display start line, captured at the frame boundary |
| reverse | input | 1 | Common direction: 0 ascending, 1 descending, captured at the frame boundary |
| frame_start | output | 1 | High on the enabled cycle of step 0 |
| scan_step | output | 7 | Current scan step, 0 to 64 |
| indicator | output | 1 | High on the indicator step (64) |
| page_addr | output | 4 | Memory page, 0 to 7 for main rows, 8 for the indicator |
| page_line | output | 3 | Row within the page |
| row_addr | output | 7 | Flat memory row, 0 to 63, or 64 for the indicator |
| com_index | output | 7 | Physical common output index, 0 to 64 |
| com_sel | output | 65 | One-hot common select |

## Verification
The bench runs full frames at start lines 0, 63 and several values in between, in both directions. It checks the modulo-64 wrap of the memory row inside a frame. A design that saturates the row, or carries the wrap into the page, would show a wrong page after row 63. It changes the start line and the direction partway through a frame and expects no effect until the next frame; a design that uses the live inputs would scroll or flip halfway down the panel. The indicator step is checked under every configuration, so an indicator row that follows the start line, or one that takes a mirrored common, is caught. Reset in the middle of a frame, and held enable, are also covered.

// File: rtl/line_scan_gen.sv
module line_scan_gen #(
  parameter int LINES      = 64,
  parameter int PAGE_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_en,
  input  logic [$clog2(LINES)-1:0] start_line,
  input  logic                 reverse,
  output logic                 frame_start,
  output logic [$clog2(LINES+1)-1:0] scan_step,
  output logic                 indicator,
  output logic [$clog2(LINES/PAGE_LINES+1)-1:0] page_addr,
  output logic [$clog2(PAGE_LINES)-1:0] page_line,
  output logic [$clog2(LINES+1)-1:0] row_addr,
  output logic [$clog2(LINES+1)-1:0] com_index,
  output logic [LINES:0]       com_sel
);
  localparam int LW    = $clog2(LINES);
  localparam int SW    = $clog2(LINES+1);
  localparam int PAGES = LINES / PAGE_LINES;
  localparam int PW    = $clog2(PAGES+1);
  localparam int LIW   = $clog2(PAGE_LINES);

  logic [SW-1:0] step_q;
  logic [LW-1:0] start_q;
  logic          rev_q;
  logic [LW-1:0] row;
  logic          last;

  assign last = step_q == SW'(LINES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q  <= '0;
      start_q <= '0;
      rev_q   <= 1'b0;
    end else if (line_en) begin
      if (last) begin
        step_q  <= '0;
        start_q <= start_line;
        rev_q   <= reverse;
      end else begin
        step_q <= step_q + SW'(1);
      end
    end
  end

  assign row         = start_q + step_q[LW-1:0];
  assign scan_step   = step_q;
  assign indicator   = last;
  assign frame_start = line_en && (step_q == '0);
  assign page_addr   = last ? PW'(PAGES) : PW'(row[LW-1:LIW]);
  assign page_line   = last ? '0 : row[LIW-1:0];
  assign row_addr    = last ? SW'(LINES) : SW'(row);
  assign com_index   = last  ? SW'(LINES) :
                       rev_q ? SW'(LINES-1) - step_q : step_q;

  for (genvar i = 0; i <= LINES; i++) begin : g_sel
    assign com_sel[i] = com_index == SW'(i);
  end
endmodule

// File: rtl/line_scan_gen_chk.sv
module line_scan_gen_chk #(
  parameter int LINES = 64,
  parameter int SW    = 7,
  parameter int LW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_en,
  input logic          frame_start,
  input logic          indicator,
  input logic          rev_q,
  input logic [LW-1:0] start_q,
  input logic [SW-1:0] scan_step,
  input logic [SW-1:0] row_addr,
  input logic [SW-1:0] com_index,
  input logic [LINES:0] com_sel
);
  p_step_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_step <= SW'(LINES));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_en && indicator |=> scan_step == '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !line_en |=> $stable(scan_step) && $stable(com_index) && $stable(row_addr));

  p_row_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    line_en && scan_step < SW'(LINES-1) |=>
      row_addr[LW-1:0] == LW'($past(row_addr[LW-1:0]) + LW'(1)));

  p_indicator_r5: assert property (@(posedge clk) disable iff (!rst_n)
    indicator |-> row_addr == SW'(LINES) && com_index == SW'(LINES));

  p_com_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_en && scan_step < SW'(LINES-1) |=>
      com_index == (rev_q ? SW'($past(com_index) - SW'(1)) : SW'($past(com_index) + SW'(1))));

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(com_sel) == 1 && com_sel[LINES] == indicator);

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_en && indicator) |=> $stable(start_q) && $stable(rev_q));

  p_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> scan_step == '0);
endmodule

bind line_scan_gen line_scan_gen_chk #(.LINES(LINES), .SW(SW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_en(line_en), .frame_start(frame_start),
  .indicator(indicator), .rev_q(rev_q), .start_q(start_q), .scan_step(scan_step),
  .row_addr(row_addr), .com_index(com_index), .com_sel(com_sel)
);

// File: tb/line_scan_gen_test.sv
module line_scan_gen_test;
  localparam int CLK = 10;
  localparam int NV  = 6;
  localparam int VS [NV] = '{0, 5, 63, 32, 7, 60};
  localparam int VR [NV] = '{0, 0, 1, 1, 0, 1};

  logic clk = 0, rst_n = 0, line_en = 0, reverse = 0;
  logic [5:0] start_line = 0;
  logic frame_start, indicator;
  logic [6:0] scan_step, row_addr, com_index;
  logic [3:0] page_addr;
  logic [2:0] page_line;
  logic [64:0] com_sel;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK/2) clk = ~clk;

  line_scan_gen uut (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .start_line(start_line),
    .reverse(reverse), .frame_start(frame_start), .scan_step(scan_step),
    .indicator(indicator), .page_addr(page_addr), .page_line(page_line),
    .row_addr(row_addr), .com_index(com_index), .com_sel(com_sel)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_sel(int com);
    tests++;
    if (com_sel !== (65'd1 << com)) begin
      fails++;
      $display("FAIL R7: actual %h expected %h", com_sel, 65'd1 << com);
    end
  endtask

  task automatic check_step(int k, int s, bit r);
    int row, com;
    row = (s + k) % 64;
    com = r ? 63 - k : k;
    chk("R3 step", scan_step, k);
    if (k < 64) begin
      chk("R4 row", row_addr, row);
      chk("R4 page", page_addr, row / 8);
      chk("R4 line", page_line, row % 8);
      chk("R6 com", com_index, com);
      chk("R5 ind low", indicator, 0);
      chk_sel(com);
    end else begin
      chk("R5 ind", indicator, 1);
      chk("R5 page", page_addr, 8);
      chk("R5 line", page_line, 0);
      chk("R5 row", row_addr, 64);
      chk("R5 com", com_index, 64);
      chk_sel(64);
    end
    chk("R9 frame_start", frame_start, (k == 0) ? 1 : 0);
  endtask

  task automatic step_to_frame(int s, bit r);
    @(negedge clk);
    start_line = 6'(s);
    reverse = r;
    line_en = 1;
    while (scan_step != 7'd64) begin
      @(posedge clk);
      @(negedge clk);
    end
    @(posedge clk);
  endtask

  task automatic run_frame(int s, bit r);
    for (int k = 0; k <= 64; k++) begin
      @(negedge clk);
      line_en = 1;
      #1;
      check_step(k, s, r);
      @(posedge clk);
    end
  endtask

  initial begin
    #(CLK * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 step", scan_step, 0);
    chk("R1 row", row_addr, 0);
    chk("R1 page", page_addr, 0);
    chk("R1 com", com_index, 0);
    chk("R9 idle", frame_start, 0);

    for (int v = 0; v < NV; v++) begin
      step_to_frame(VS[v], VR[v] != 0);
      run_frame(VS[v], VR[v] != 0);
    end

    @(negedge clk);
    line_en = 1;
    repeat (5) begin @(posedge clk); @(negedge clk); end
    line_en = 0;
    repeat (4) begin @(posedge clk); @(negedge clk); end
    #1;
    chk("R2 hold", scan_step, 5);
    chk("R2 hold row", row_addr, (60 + 5) % 64);
    chk("R9 no en", frame_start, 0);

    step_to_frame(5, 0);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); line_en = 1; @(posedge clk);
    end
    @(negedge clk);
    start_line = 6'd20;
    reverse = 1;
    for (int k = 10; k < 64; k++) begin
      line_en = 1;
      #1;
      chk("R8 row", row_addr, (5 + k) % 64);
      chk("R8 com", com_index, k);
      @(posedge clk);
      @(negedge clk);
    end
    line_en = 1;
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R8 new row", row_addr, 20);
    chk("R8 new com", com_index, 63);

    @(negedge clk);
    repeat (7) begin @(posedge clk); @(negedge clk); end
    rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    line_en = 0;
    #1;
    chk("R1 mid reset step", scan_step, 0);
    chk("R1 mid reset row", row_addr, 0);
    chk("R1 mid reset com", com_index, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule